// File: doc/BRIEF.md
# Dual-Clock Registered Bus Transceiver

This block couples a parallel data port to a shared bidirectional bus of five lanes. Each lane has two registers. A transmit register loads the lane's data input on the rising edge of the transmit clock. A receive register samples the lane's bus line on the rising edge of a second, unrelated receive clock.

A lane drives its transmit register onto its bus line only while that lane's own enable is high. With the enable low, the lane lets go of the line (high impedance), and another agent on the bus may drive it. The receive registers capture whatever the lines carry: the block's own drive, which gives a loopback path, or a foreign one. The parallel outputs show the receive registers, never the live bus.

One active-high master reset clears all registers in both domains, asynchronously. The two clocks are not synchronised with each other. The data path is a plain registered transfer with no handshake, so there is no back-pressure: every transmit edge overwrites the transmit registers and every receive edge overwrites the receive registers.

Top module: `regbus_xcvr`

## Requirements
- R1: On each rising edge of `tx_clk_i`, all lanes' transmit registers load `tx_data_i` together.
- R2: While `lane_en_i[i]` is 1, `bus_io[i]` carries lane i's transmit register value.
- R3: While `lane_en_i[i]` is 0, lane i releases `bus_io[i]` to high impedance, so a value driven by an outside agent appears on the line and is the one sampled.
- R4: Each enable bit governs only its own lane; any of the 32 enable patterns gives the mixed per-lane result of R2 and R3.
- R5: On each rising edge of `rx_clk_i`, all lanes' receive registers capture the current `bus_io` value together.
- R6: `rx_data_o` shows the receive registers; a change on `bus_io` between receive edges leaves `rx_data_o` unchanged.
- R7: While `rst_i` is 1, every transmit and receive register is 0, at once and without any clock edge, and clock edges do not disturb it. This shows as `rx_data_o` = 0, and as 0 on every enabled bus lane.
- R8: With `lane_en_i[i]` at 1 across a receive edge, `rx_data_o[i]` afterwards equals the transmit register value that lane drove (loopback).
- R9: The domains are independent: a transmit edge does not change `rx_data_o`, and a receive edge does not change the driven bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_i | input | 1 | Master reset, active high, asynchronous |
| tx_clk_i | input | 1 | Transmit register clock |
| rx_clk_i | input | 1 | Receive register clock |
| tx_data_i | input | LANES (5) | Parallel data to transmit |
| lane_en_i | input | LANES (5) | Per-lane bus drive enable |
| bus_io | inout | LANES (5) | Shared bus lines, released to Z when a lane is disabled |
| rx_data_o | output | LANES (5) | Receive register contents |

## Verification
A transmit register holding a stale or wrong bit shows on its bus line one transmit edge after the load, but only while that lane is enabled. With the lane released it stays hidden until loopback makes it visible on `rx_data_o` after the next receive edge. A receive register that follows the bus combinationally, or picks the wrong lane, shows at once when an outside agent changes a released line between receive edges. Reset faults show within a fraction of a clock period, because reset is checked with no clock edge in between.

// File: rtl/bxcvr_pkg.sv
package bxcvr_pkg;
  localparam int unsigned BXC_LANES = 5;

  // Value seen on a lane: own drive when enabled, else the line (foreign).
  function automatic logic [BXC_LANES-1:0] bxc_merge(
    input logic [BXC_LANES-1:0] own,
    input logic [BXC_LANES-1:0] en,
    input logic [BXC_LANES-1:0] ext
  );
    return (own & en) | (ext & ~en);
  endfunction
endpackage

// File: rtl/bxcvr_txreg.sv
module bxcvr_txreg #(
  parameter int unsigned LANES = bxcvr_pkg::BXC_LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] d,
  output logic [LANES-1:0] q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  AST_TX_LOAD: assert property (@(posedge clk) disable iff (rst)
    !rst |=> q == $past(d)) else $error("tx load"); // R1

  always @(posedge clk) begin
    if (rst) AST_TX_RESET: assert (q == '0) else $error("tx reset"); // R7
  end
endmodule

// File: rtl/bxcvr_lane_io.sv
module bxcvr_lane_io #(
  parameter int unsigned LANES = bxcvr_pkg::BXC_LANES
) (
  input  logic [LANES-1:0] drv,
  input  logic [LANES-1:0] en,
  inout  wire  [LANES-1:0] pad,
  output logic [LANES-1:0] sense
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign pad[g]   = en[g] ? drv[g] : 1'bz;
    assign sense[g] = pad[g];
  end
endmodule

// File: rtl/bxcvr_rxreg.sv
module bxcvr_rxreg #(
  parameter int unsigned LANES = bxcvr_pkg::BXC_LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] line,
  output logic [LANES-1:0] q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) q <= '0;
    else     q <= line;
  end

  AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> q === $past(line)) else $error("rx capture"); // R5

  always @(posedge clk) begin
    if (rst) AST_RX_RESET: assert (q == '0) else $error("rx reset"); // R7
  end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int unsigned LANES = bxcvr_pkg::BXC_LANES
) (
  input  logic             rst_i,
  input  logic             tx_clk_i,
  input  logic             rx_clk_i,
  input  logic [LANES-1:0] tx_data_i,
  input  logic [LANES-1:0] lane_en_i,
  inout  wire  [LANES-1:0] bus_io,
  output logic [LANES-1:0] rx_data_o
);
  logic [LANES-1:0] tx_q;
  logic [LANES-1:0] line_v;

  bxcvr_txreg #(.LANES(LANES)) u_tx (
    .clk(tx_clk_i), .rst(rst_i), .d(tx_data_i), .q(tx_q)
  );

  bxcvr_lane_io #(.LANES(LANES)) u_io (
    .drv(tx_q), .en(lane_en_i), .pad(bus_io), .sense(line_v)
  );

  bxcvr_rxreg #(.LANES(LANES)) u_rx (
    .clk(rx_clk_i), .rst(rst_i), .line(line_v), .q(rx_data_o)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    AST_LOOPBACK: assert property (@(posedge rx_clk_i) disable iff (rst_i)
      lane_en_i[g] |=> rx_data_o[g] === $past(tx_q[g])) else $error("loopback"); // R8
  end
endmodule

// File: tb/regbus_xcvr_tb_top.sv
module regbus_xcvr_tb_top;
  localparam int unsigned L = 5;

  logic         rst_i = 1'b1;
  logic         tx_clk_i = 1'b0;
  logic         rx_clk_i = 1'b0;
  logic [L-1:0] tx_data_i = '0;
  logic [L-1:0] lane_en_i = '0;
  logic [L-1:0] ext_val = '0;
  logic [L-1:0] ext_en = '0;
  wire  [L-1:0] bus_w;
  logic [L-1:0] rx_data_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  for (genvar g = 0; g < L; g++) begin : g_ext
    assign bus_w[g] = ext_en[g] ? ext_val[g] : 1'bz;
  end

  regbus_xcvr #(.LANES(L)) dut_i (
    .rst_i(rst_i), .tx_clk_i(tx_clk_i), .rx_clk_i(rx_clk_i),
    .tx_data_i(tx_data_i), .lane_en_i(lane_en_i),
    .bus_io(bus_w), .rx_data_o(rx_data_o)
  );

  always #10 tx_clk_i = ~tx_clk_i;   // 50 MHz transmit clock

  task automatic check(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rx_pulse();
    rx_clk_i = 1'b1;
    #3;
    rx_clk_i = 1'b0;
    #2;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [L-1:0] exp_bus;
    logic [L-1:0] held;
    // reset state, enables on so bus shows reset transmit regs
    lane_en_i = '1;
    tx_data_i = '1;
    @(posedge tx_clk_i); #3;
    check("R7 reset bus", bus_w, '0);
    rx_pulse();
    check("R7 reset rx", rx_data_o, '0);
    @(negedge tx_clk_i);
    rst_i = 1'b0;

    // sweep every data pattern against every enable pattern
    for (int e = 0; e < 32; e++) begin
      for (int d = 0; d < 32; d++) begin
        @(negedge tx_clk_i);
        lane_en_i = e[L-1:0];
        tx_data_i = d[L-1:0];
        ext_val   = d[L-1:0] ^ 5'b10110 ^ e[L-1:0];
        ext_en    = ~e[L-1:0];
        @(posedge tx_clk_i); #3;
        exp_bus = (d[L-1:0] & e[L-1:0]) | (ext_val & ~e[L-1:0]);
        check("R1 R2 R3 R4 bus", bus_w, exp_bus);
        held = rx_data_o;
        rx_pulse();
        check("R5 R8 capture", rx_data_o, exp_bus);
        check("R9 rx edge keeps bus", bus_w, exp_bus);
        ext_val = ~ext_val;
        #2;
        check("R6 rx holds", rx_data_o, exp_bus);
        if (held !== exp_bus) begin
          @(negedge tx_clk_i);
          check("R9 held pre-load", rx_data_o, exp_bus);
        end
      end
    end

    // transmit edge must not touch receive output
    @(negedge tx_clk_i);
    ext_en = '0; lane_en_i = '1; tx_data_i = 5'b01011;
    @(posedge tx_clk_i); #3;
    rx_pulse();
    check("R8 loopback", rx_data_o, 5'b01011);
    @(negedge tx_clk_i);
    tx_data_i = 5'b10100;
    @(posedge tx_clk_i); #3;
    check("R9 tx edge keeps rx", rx_data_o, 5'b01011);
    check("R1 new load", bus_w, 5'b10100);

    // asynchronous reset between edges, held across clock edges
    @(negedge tx_clk_i); #4;
    rst_i = 1'b1;
    #1;
    check("R7 async rx", rx_data_o, '0);
    check("R7 async tx", bus_w, '0);
    tx_data_i = '1;
    @(posedge tx_clk_i); #3;
    rx_pulse();
    check("R7 hold tx", bus_w, '0);
    check("R7 hold rx", rx_data_o, '0);
    @(negedge tx_clk_i);
    rst_i = 1'b0;
    @(posedge tx_clk_i); #3;
    check("R1 after reset", bus_w, '1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule